// File: doc/BRIEF.md
# TLB Shootdown Command Sequencer

This block runs one translation-invalidate operation on a memory-mapped shootdown unit. A client offers a request that carries a 20-bit process ID, a 64-bit virtual address and a page size in bytes. The block then drives a small 64-bit register port. It writes the abbreviated-address register only when the address is nonzero. Next it writes a launch word built from the request. After that it keeps reading the status register until the pending flag clears. If that takes too long, the block gives up.

The request side uses a valid/ready handshake. The block reports the result with a one-cycle `done` or `timeout` pulse and holds the last status word it read. The master side raises `bus_req` and holds the offset, direction and write data steady until the target answers with `bus_ack`.

Top module: `tlbsd_seq`

## Requirements
- R1: `req_ready` is high only when idle, and a request is taken on `req_valid && req_ready`. No further request is taken until `done` or `timeout` has pulsed for exactly one cycle, and `req_ready` is high again on the cycle after that pulse.
- R2: Bus accesses follow a fixed order: the optional write to offset 0x08, then one write to offset 0x00, then reads from offset 0x10 only. No other offset is used.
- R3: The write to offset 0x08 happens exactly when the request address is nonzero. Its data is the address with bits 11:0 cleared.
- R4: The launch word has bit 63 = 1, bits 62:61 = 2'b10 and bit 50 = 1. Bits 60:53, 49, 45, 24, 23 and 21:0 are 0.
- R5: For a nonzero address, bits 52:51 are 2'b00 and bit 22 is 0. For a zero address, bits 52:51 are 2'b01 and bit 22 is 1.
- R6: Bits 44:25 of the launch word carry the process ID.
- R7: Bits 48:46 of the launch word carry the page code: 0x1000 bytes gives 3'b000, 0x200000 gives 3'b001, 0x40000000 gives 3'b010, and every other size gives 3'b101.
- R8: The first status read whose bit 63 is 0 ends the operation with a `done` pulse. `last_status` then equals that read value, and exactly one more read has been made than there were pending reads.
- R9: A cycle counter starts when the launch write is acknowledged and is tested before each status read. Once it reaches `TIMEOUT_CYC`, no further read is issued and `timeout` pulses instead. `last_status` then holds the last read value, which has bit 63 set.
- R10: While `bus_req` is high and `bus_ack` is low, the next cycle keeps `bus_req` high with unchanged `bus_we`, `bus_ofs` and `bus_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_pid | input | 20 | Process ID to invalidate |
| req_addr | input | 64 | Virtual address; zero selects PID-wide invalidation |
| req_pgsize | input | 64 | Page size in bytes |
| done | output | 1 | One-cycle pulse when the operation completed |
| timeout | output | 1 | One-cycle pulse when polling gave up |
| last_status | output | 64 | Last status word read |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_ofs | output | ADDR_W | Register offset within the window |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Access accepted or completed |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` on reads |

## Verification
The hardest situation to reach from the ports is the timeout path. It needs a target that stays pending long enough for the cycle counter to run out while reads are still in flight. It also needs the check that no further read starts afterwards. The bench's target model keeps the pending bit set for a per-operation number of reads. It also adds a random acknowledge delay. Operations use either a small count, which completes, or a count that never runs out, which forces expiry. Zero and nonzero addresses are mixed with exact and off-size page sizes to cover both launch formats and the default page code.

// File: rtl/tlbsd_pkg.sv
package tlbsd_pkg;
  localparam int WORD_W = 64;
  localparam int PID_W  = 20;

  localparam int OFS_LAUNCH = 'h00;
  localparam int OFS_AVA    = 'h08;
  localparam int OFS_STAT   = 'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_AVA, ST_LAUNCH, ST_CHECK, ST_POLL, ST_DONE, ST_TMO
  } seq_state_t;

  function automatic logic [2:0] page_code(input logic [WORD_W-1:0] bytes);
    case (bytes)
      64'h0000_0000_0000_1000: page_code = 3'b000;
      64'h0000_0000_0020_0000: page_code = 3'b001;
      64'h0000_0000_4000_0000: page_code = 3'b010;
      default:                 page_code = 3'b101;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] ava_word(input logic [WORD_W-1:0] va);
    ava_word = va & ~64'hFFF;
  endfunction

  function automatic logic [WORD_W-1:0] launch_word(
      input logic [PID_W-1:0] pid, input logic by_pid, input logic [2:0] code);
    logic [WORD_W-1:0] w;
    w = (64'h1 << 63) | (64'h2 << 61) | (64'h1 << 50);
    w = w | ({62'd0, 1'b0, by_pid} << 51);
    w = w | ({61'd0, code} << 46);
    w = w | ({44'd0, pid} << 25);
    w = w | ({63'd0, by_pid} << 22);
    launch_word = w;
  endfunction
endpackage

// File: rtl/tlbsd_cmd_fmt.sv
module tlbsd_cmd_fmt
  import tlbsd_pkg::*;
(
  input  logic [PID_W-1:0]  pid,
  input  logic [WORD_W-1:0] va,
  input  logic [WORD_W-1:0] pgsize,
  output logic              need_ava,
  output logic [WORD_W-1:0] ava_data,
  output logic [WORD_W-1:0] launch_data
);
  logic by_pid;

  assign by_pid      = (va == '0);
  assign need_ava    = !by_pid;
  assign ava_data    = ava_word(va);
  assign launch_data = launch_word(pid, by_pid, page_code(pgsize));
endmodule

// File: rtl/tlbsd_poll_timer.sv
module tlbsd_poll_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/tlbsd_seq.sv
module tlbsd_seq
  import tlbsd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [19:0]       req_pid,
  input  logic [63:0]       req_addr,
  input  logic [63:0]       req_pgsize,
  output logic              done,
  output logic              timeout,
  output logic [63:0]       last_status,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_ofs,
  output logic [63:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [63:0]       bus_rdata
);
  localparam logic [ADDR_W-1:0] A_LAUNCH = ADDR_W'(OFS_LAUNCH);
  localparam logic [ADDR_W-1:0] A_AVA    = ADDR_W'(OFS_AVA);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);

  seq_state_t st, st_nx;
  logic        need_ava_c, need_ava_q;
  logic [63:0] ava_c, ava_q, launch_c, launch_q;

  // named internal events
  logic accept, ava_ack, launch_ack, stat_ack, stat_pending, tmr_expired;

  tlbsd_cmd_fmt u_fmt (
    .pid        (req_pid),
    .va         (req_addr),
    .pgsize     (req_pgsize),
    .need_ava   (need_ava_c),
    .ava_data   (ava_c),
    .launch_data(launch_c)
  );

  tlbsd_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (launch_ack),
    .expired(tmr_expired)
  );

  assign accept       = req_valid && req_ready;
  assign ava_ack      = (st == ST_AVA) && bus_ack;
  assign launch_ack   = (st == ST_LAUNCH) && bus_ack;
  assign stat_ack     = (st == ST_POLL) && bus_ack;
  assign stat_pending = bus_rdata[63];

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (accept) st_nx = need_ava_c ? ST_AVA : ST_LAUNCH;
      ST_AVA:    if (ava_ack) st_nx = ST_LAUNCH;
      ST_LAUNCH: if (launch_ack) st_nx = ST_CHECK;
      ST_CHECK:  st_nx = tmr_expired ? ST_TMO : ST_POLL;
      ST_POLL:   if (stat_ack) st_nx = stat_pending ? ST_CHECK : ST_DONE;
      ST_DONE:   st_nx = ST_IDLE;
      ST_TMO:    st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      need_ava_q  <= 1'b0;
      ava_q       <= '0;
      launch_q    <= '0;
      last_status <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        need_ava_q <= need_ava_c;
        ava_q      <= ava_c;
        launch_q   <= launch_c;
      end
      if (stat_ack) last_status <= bus_rdata;
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign done      = (st == ST_DONE);
  assign timeout   = (st == ST_TMO);
  assign bus_req   = (st == ST_AVA) || (st == ST_LAUNCH) || (st == ST_POLL);
  assign bus_we    = (st == ST_AVA) || (st == ST_LAUNCH);

  always_comb begin
    case (st)
      ST_AVA:  bus_ofs = A_AVA;
      ST_POLL: bus_ofs = A_STAT;
      default: bus_ofs = A_LAUNCH;
    endcase
  end

  assign bus_wdata = (st == ST_AVA) ? ava_q : (st == ST_LAUNCH) ? launch_q : '0;

  logic unused_ok;
  assign unused_ok = need_ava_q;
endmodule

// File: rtl/tlbsd_seq_chk.sv
module tlbsd_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              timeout,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_ofs,
  input logic [63:0]       bus_wdata,
  input logic              bus_ack,
  input logic [63:0]       bus_rdata,
  input logic              stat_ack
);
  logic lw;
  assign lw = bus_req && bus_we && (bus_ofs == ADDR_W'(0));

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_ofs) && $stable(bus_wdata));

  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> !done && !timeout && req_ready);

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready);

  assert_fixed_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lw |-> bus_wdata[63:61] == 3'b110 && bus_wdata[50] && bus_wdata[60:53] == 8'd0
           && !bus_wdata[49] && !bus_wdata[45] && !bus_wdata[24] && !bus_wdata[23]
           && bus_wdata[21:0] == 22'd0);

  assert_criteria_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lw |-> !bus_wdata[52] && (bus_wdata[51] == bus_wdata[22]));

  assert_page_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lw |-> bus_wdata[48:46] inside {3'b000, 3'b001, 3'b010, 3'b101});

  assert_ava_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_ofs == ADDR_W'(8) |-> bus_wdata[11:0] == 12'd0);

  assert_read_ofs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> bus_ofs == ADDR_W'(16));

  assert_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ack && !bus_rdata[63] |=> done);

  assert_still_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ack && bus_rdata[63] |=> !done && !timeout);
endmodule

bind tlbsd_seq tlbsd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .done     (done),
  .timeout  (timeout),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_ofs  (bus_ofs),
  .bus_wdata(bus_wdata),
  .bus_ack  (bus_ack),
  .bus_rdata(bus_rdata),
  .stat_ack (stat_ack)
);

// File: tb/tlbsd_seq_bench.sv
module tlbsd_seq_bench;
  localparam int T_CYC = 40;
  localparam int NEVER = 1000000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [19:0] req_pid = '0;
  logic [63:0] req_addr = '0, req_pgsize = '0;
  logic req_ready, done, timeout, bus_req, bus_we;
  logic [63:0] last_status, bus_wdata;
  logic [7:0] bus_ofs;
  logic bus_ack = 0;
  logic [63:0] bus_rdata = '0;

  always #4 clk = ~clk;

  tlbsd_seq #(.ADDR_W(8), .TIMEOUT_CYC(T_CYC)) u_tlbsd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_addr(req_addr), .req_pgsize(req_pgsize),
    .done(done), .timeout(timeout), .last_status(last_status),
    .bus_req(bus_req), .bus_we(bus_we), .bus_ofs(bus_ofs), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int checks = 0, fails = 0;

  function automatic logic [63:0] stat_word(input int idx, input bit pend);
    return {pend, 31'd0, 16'hC0DE, idx[15:0]};
  endfunction

  function automatic logic [2:0] exp_code(input logic [63:0] sz);
    if (sz == 64'd4096) return 3'd0;
    if (sz == 64'd2097152) return 3'd1;
    if (sz == 64'd1073741824) return 3'd2;
    return 3'd5;
  endfunction

  function automatic logic [63:0] exp_launch(input logic [19:0] pid, input logic [63:0] a,
                                             input logic [63:0] sz);
    logic [63:0] w = '0;
    w[63] = 1'b1; w[62] = 1'b1; w[50] = 1'b1;
    if (a == 0) begin w[51] = 1'b1; w[22] = 1'b1; end
    w[44:25] = pid;
    w[48:46] = exp_code(sz);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // target model
  int cyc = 0, dly = 0, rd_cnt = 0, ava_cnt = 0, lnch_cnt = 0, lnch_cyc = 0;
  int npolls = 0, base_lnch = 0;
  logic [63:0] ava_val = '0, lnch_val = '0;
  bit order_err = 0, ofs_err = 0, hold_err = 0;
  logic p_req = 0, p_ack = 0, p_we = 0;
  logic [7:0] p_ofs = '0;
  logic [63:0] p_wd = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    p_req <= bus_req; p_ack <= bus_ack; p_we <= bus_we; p_ofs <= bus_ofs; p_wd <= bus_wdata;
    if (rst_n && p_req && !p_ack &&
        !(bus_req && bus_we == p_we && bus_ofs == p_ofs && bus_wdata == p_wd))
      hold_err <= 1;
    bus_ack <= 0;
    if (rst_n && bus_req && !bus_ack) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        bus_ack <= 1;
        dly <= int'($urandom % 3);
        if (bus_we) begin
          if (bus_ofs == 8'h08) begin
            ava_cnt <= ava_cnt + 1; ava_val <= bus_wdata;
            if (lnch_cnt != base_lnch) order_err <= 1;
          end else if (bus_ofs == 8'h00) begin
            lnch_cnt <= lnch_cnt + 1; lnch_val <= bus_wdata; lnch_cyc <= cyc;
          end else ofs_err <= 1;
        end else begin
          if (bus_ofs != 8'h10) ofs_err <= 1;
          if (lnch_cnt == base_lnch) order_err <= 1;
          bus_rdata <= stat_word(rd_cnt, (rd_cnt - base_rd) < npolls);
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end
  int base_rd = 0;

  task automatic run_op(input logic [19:0] pid, input logic [63:0] a,
                        input logic [63:0] sz, input int np);
    int b_ava, b_rd, n;
    bit busy_err, to_exp;
    logic [63:0] el;
    b_ava = ava_cnt; b_rd = rd_cnt; base_rd = rd_cnt; base_lnch = lnch_cnt;
    npolls = np; busy_err = 0; to_exp = (np >= NEVER);
    @(negedge clk);
    chk(req_ready, "R1 ready when idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1; req_pid = pid; req_addr = a; req_pgsize = sz;
    @(negedge clk);
    req_valid = 0; req_addr = $urandom; req_pgsize = $urandom;
    n = 0;
    while (!done && !timeout && n < 3000) begin
      if (req_ready) busy_err = 1;
      @(negedge clk); n++;
    end
    chk(n < 3000, "R1 operation ended", n, 0);
    chk(!busy_err, "R1 not ready while busy", {63'd0, busy_err}, 0);
    chk(done == !to_exp && timeout == to_exp, to_exp ? "R9 timeout pulse" : "R8 done pulse",
        {62'd0, done, timeout}, to_exp ? 64'd1 : 64'd2);
    chk(ava_cnt - b_ava == (a != 0 ? 1 : 0), "R3 address write count", ava_cnt - b_ava, a != 0);
    if (a != 0) chk(ava_val == (a & ~64'hFFF), "R3 address write data", ava_val, a & ~64'hFFF);
    chk(lnch_cnt - base_lnch == 1, "R2 one launch write", lnch_cnt - base_lnch, 1);
    el = exp_launch(pid, a, sz);
    chk(lnch_val == el, "R4 launch word", lnch_val, el);
    chk(lnch_val[52:51] == el[52:51] && lnch_val[22] == el[22], "R5 criteria", lnch_val, el);
    chk(lnch_val[44:25] == pid, "R6 pid field", lnch_val[44:25], pid);
    chk(lnch_val[48:46] == exp_code(sz), "R7 page code", lnch_val[48:46], exp_code(sz));
    chk(!order_err && !ofs_err, "R2 order and offsets", {62'd0, order_err, ofs_err}, 0);
    chk(!hold_err, "R10 request held", {63'd0, hold_err}, 0);
    if (!to_exp) begin
      chk(rd_cnt - b_rd == np + 1, "R8 read count", rd_cnt - b_rd, np + 1);
      chk(last_status == stat_word(rd_cnt - 1, 0), "R8 last status", last_status,
          stat_word(rd_cnt - 1, 0));
    end else begin
      chk(last_status == stat_word(rd_cnt - 1, 1), "R9 last status", last_status,
          stat_word(rd_cnt - 1, 1));
      chk(cyc - lnch_cyc >= T_CYC && cyc - lnch_cyc <= T_CYC + 14, "R9 timeout window",
          cyc - lnch_cyc, T_CYC);
    end
    @(negedge clk);
    chk(!done && !timeout && req_ready, "R1 single pulse then ready",
        {61'd0, done, timeout, req_ready}, 64'd1);
    if (to_exp) begin
      n = rd_cnt;
      repeat (5) @(negedge clk);
      chk(rd_cnt == n && !bus_req, "R9 no read after timeout", rd_cnt, n);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !timeout && !bus_req, "R1 reset state",
        {60'd0, req_ready, done, timeout, bus_req}, 64'h8);
    rst_n = 1;
    run_op(20'h12345, 64'h0, 64'h1000, 0);
    run_op(20'hFFFFF, 64'hDEAD_BEEF_CAFE_1FFF, 64'h1000, 2);
    run_op(20'h00001, 64'h0000_7FFF_0000_0000, 64'h200000, 1);
    run_op(20'h0ABCD, 64'h1, 64'h40000000, 3);
    run_op(20'h00000, 64'h0000_0000_0001_0000, 64'h10000, 0);
    run_op(20'h55555, 64'h0, 64'h2000, 1);
    run_op(20'h0F0F0, 64'hFFFF_FFFF_FFFF_F000, 64'h0, NEVER);
    run_op(20'h33333, 64'h0, 64'h200000, NEVER);
    for (int i = 0; i < 30; i++) begin
      logic [63:0] a, sz;
      int pick;
      a = ($urandom % 3 == 0) ? 64'd0 : {$urandom, $urandom};
      pick = int'($urandom % 6);
      sz = pick == 0 ? 64'h1000 : pick == 1 ? 64'h200000 : pick == 2 ? 64'h40000000 :
           pick == 3 ? 64'h10000 : {$urandom, $urandom};
      run_op(20'($urandom), a, sz, int'($urandom % 4));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule